// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns 32-bit virtual addresses issued by a processor into 29-bit physical addresses. Pages are 256 KiB, so the low 18 address bits are the page offset and are copied unchanged into the physical address. The upper 14 bits are the virtual page number, which selects one entry of a flat page table. The table lives in memory at the address given by the page table base input. A small fully associative translation cache keeps recently used entries, with a parameter for its entry count (default 8) and round-robin replacement.

The processor presents an address and an access kind with a valid/ready handshake. One cycle after a cache hit, or one cycle after the memory returns the table entry on a miss, the block gives a single-cycle response. The response carries the physical address and a fault code: no fault, page fault (the entry is absent), or protection fault (the entry forbids this kind of access). Read, write and execute rights are checked on every access. A flush input empties the cache on a context switch. A flush that arrives during a table read cancels that read.

Top module: `xlate_top`

## Requirements
- R1: On a successful translation, resp_paddr equals {ppn, vaddr[17:0]}. The ppn is the 11-bit field in bits [10:0] of the page table entry. The entry layout is [16] valid, [15] dirty, [14:11] rights, [10:0] ppn.
- R2: On a cache miss, mem_req rises in the cycle after acceptance and holds, with a stable mem_addr, until mem_ack. mem_addr equals ptbr + 4 * vaddr[31:18].
- R3: An entry with valid bit 0 gives resp_fault = 1 (page fault), resp_paddr = 0 and resp_dirty = 0. It is not cached, so the next access to that page reads the table again.
- R4: The rights field uses bit 0 = readable, bit 1 = writable, bit 2 = executable. req_kind 0 (load) needs readable, 1 (store) needs writable, and 2 (fetch) needs executable. A missing right gives resp_fault = 2 (protection fault), resp_paddr = 0 and resp_dirty = 0. resp_fault = 0 means no fault.
- R5: On a cache hit, resp_valid is high for exactly the one cycle after acceptance, and no memory read is made.
- R6: On a miss, resp_valid is high for the one cycle after mem_ack. A valid entry is then cached, so the next access to the same page hits.
- R7: While flush is high, req_ready is low. After a flush, every page misses until it is read again.
- R8: A flush during a table read cancels the read. That request gets no response and its entry is not cached.
- R9: With N cache entries and no flush, caching the (N+1)-th distinct page evicts the page cached first. Other pages stay cached.
- R10: resp_dirty reports the dirty bit of the cached entry after the access. A successful store sets it, and it stays set for later accesses to that page until a flush. A newly cached entry starts with the table entry's dirty bit.
- R11: Only one request is in flight at a time. req_ready is high only when the block is idle, and it is high after reset, with resp_valid and mem_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached translations |
| ptbr | input | 29 | Physical base address of the page table |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| resp_valid | output | 1 | Single-cycle response strobe |
| resp_paddr | output | 29 | Physical address, zero on a fault |
| resp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| resp_dirty | output | 1 | Dirty state of the cached entry after the access |
| mem_req | output | 1 | Page table read request |
| mem_addr | output | 29 | Page table entry address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 17 | Page table entry |

## Verification
The assertions assume the memory raises mem_ack only while mem_req is high, with mem_rdata valid in the same cycle. They also assume ptbr and the table contents do not change while pages are cached, and that req_kind never takes the value 3. The bench memory answers a fixed two cycles after mem_req is first seen, and drops its count when mem_req falls. The bench changes ptbr and the table only at reset, and it drives only the three defined access kinds.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 18;
    localparam int PA_W   = 29;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int RGT_W  = 4;
    localparam int PTE_W  = PPN_W + RGT_W + 2;
    localparam int STRIDE = 2;

    typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_e;
    typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_PAGE = 2'd1, FLT_PROT = 2'd2} flt_e;
    typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_RESP} st_e;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [RGT_W-1:0] rights;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic             dirty;
        logic [RGT_W-1:0] rights;
        logic [PPN_W-1:0] ppn;
    } tlb_ent_t;

    function automatic logic right_ok(acc_e kind, logic [RGT_W-1:0] r);
        case (kind)
            ACC_LOAD:  return r[0];
            ACC_STORE: return r[1];
            ACC_FETCH: return r[2];
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic [PA_W-1:0] pte_addr(logic [PA_W-1:0] base, logic [VPN_W-1:0] vpn);
        return base + PA_W'({vpn, {STRIDE{1'b0}}});
    endfunction
endpackage

// File: rtl/xlate_rights.sv
module xlate_rights
    import xlate_pkg::*;
(
    input  acc_e             kind,
    input  logic             pvalid,
    input  logic [RGT_W-1:0] rights,
    output flt_e             fault
);
    always_comb begin
        if (!pvalid)
            fault = FLT_PAGE;
        else if (!right_ok(kind, rights))
            fault = FLT_PROT;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xlate_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output tlb_ent_t         lk_ent,
    input  logic             ins_en,
    input  tlb_ent_t         ins_ent,
    input  logic             dset_en,
    input  logic [IDX_W-1:0] dset_idx
);
    tlb_ent_t           slot [ENTRIES];
    logic [ENTRIES-1:0] hv;
    logic [IDX_W-1:0]   rr;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hv[g] = slot[g].valid && (slot[g].vpn == lk_vpn);
    end

    always_comb begin
        lk_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (hv[i]) lk_idx = IDX_W'(i);
        lk_hit = |hv;
        lk_ent = slot[lk_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) slot[i] <= '0;
            rr <= '0;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) slot[i].valid <= 1'b0;
            rr <= '0;
        end else begin
            if (ins_en) begin
                slot[rr] <= ins_ent;
                rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
            end
            if (dset_en) slot[dset_idx].dirty <= 1'b1;
        end
    end

    // R9
    tlb_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(hv))
        else $error("tlb_onehot_chk");

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst) flush |=> !lk_hit)
        else $error("flush_clear_chk");
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
    import xlate_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [PA_W-1:0]  ptbr,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic [1:0]       resp_fault,
    output logic             resp_dirty,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_hit,
    input  logic [IDX_W-1:0] lk_idx,
    input  tlb_ent_t         lk_ent,
    output logic             ins_en,
    output tlb_ent_t         ins_ent,
    output logic             dset_en,
    output logic [IDX_W-1:0] dset_idx,
    output acc_e             chk_kind,
    output logic             chk_valid,
    output logic [RGT_W-1:0] chk_rights,
    input  flt_e             chk_fault
);
    st_e              st;
    logic [VPN_W-1:0] r_vpn;
    logic [OFF_W-1:0] r_off;
    acc_e             r_kind;
    pte_t             wpte;
    logic             in_walk, accept, ok, st_ok;

    assign wpte      = pte_t'(mem_rdata);
    assign in_walk   = (st == ST_WALK);
    assign req_ready = (st == ST_IDLE) && !flush;
    assign accept    = req_valid && req_ready;
    assign lk_vpn    = req_vaddr[VA_W-1:OFF_W];

    assign chk_kind   = in_walk ? r_kind : acc_e'(req_kind);
    assign chk_valid  = in_walk ? wpte.valid : 1'b1;
    assign chk_rights = in_walk ? wpte.rights : lk_ent.rights;
    assign ok         = (chk_fault == FLT_NONE);
    assign st_ok      = ok && (chk_kind == ACC_STORE);

    assign mem_req  = in_walk;
    assign mem_addr = pte_addr(ptbr, r_vpn);

    assign ins_en  = in_walk && mem_ack && !flush && wpte.valid;
    assign ins_ent = '{valid: 1'b1, vpn: r_vpn, dirty: wpte.dirty | st_ok,
                       rights: wpte.rights, ppn: wpte.ppn};

    assign dset_en  = accept && lk_hit && st_ok;
    assign dset_idx = lk_idx;

    assign resp_valid = (st == ST_RESP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            r_vpn      <= '0;
            r_off      <= '0;
            r_kind     <= ACC_LOAD;
            resp_paddr <= '0;
            resp_fault <= FLT_NONE;
            resp_dirty <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        r_vpn  <= req_vaddr[VA_W-1:OFF_W];
                        r_off  <= req_vaddr[OFF_W-1:0];
                        r_kind <= acc_e'(req_kind);
                        if (lk_hit) begin
                            resp_paddr <= ok ? {lk_ent.ppn, req_vaddr[OFF_W-1:0]} : '0;
                            resp_fault <= chk_fault;
                            resp_dirty <= ok && (lk_ent.dirty || st_ok);
                            st         <= ST_RESP;
                        end else begin
                            st <= ST_WALK;
                        end
                    end
                end
                ST_WALK: begin
                    if (flush) begin
                        st <= ST_IDLE;
                    end else if (mem_ack) begin
                        resp_paddr <= ok ? {wpte.ppn, r_off} : '0;
                        resp_fault <= chk_fault;
                        resp_dirty <= ok && (wpte.dirty || st_ok);
                        st         <= ST_RESP;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5
    hit_resp_chk: assert property (@(posedge clk) disable iff (rst)
        accept && lk_hit |=> resp_valid && !mem_req)
        else $error("hit_resp_chk");

    // R2
    walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack && !flush |=> mem_req && $stable(mem_addr))
        else $error("walk_hold_chk");

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && flush |=> !resp_valid && !mem_req)
        else $error("abort_chk");

    // R11
    one_out_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready)
        else $error("one_out_chk");

    // R3
    page_fault_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && !flush && !wpte.valid |=> resp_valid && resp_fault == FLT_PAGE)
        else $error("page_fault_chk");
endmodule

// File: rtl/xlate_top.sv
module xlate_top
    import xlate_pkg::*;
#(
    parameter int TLB_ENTRIES = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic [28:0]  ptbr,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [31:0]  req_vaddr,
    input  logic [1:0]   req_kind,
    output logic         resp_valid,
    output logic [28:0]  resp_paddr,
    output logic [1:0]   resp_fault,
    output logic         resp_dirty,
    output logic         mem_req,
    output logic [28:0]  mem_addr,
    input  logic         mem_ack,
    input  logic [16:0]  mem_rdata
);
    localparam int IDX_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;

    logic [VPN_W-1:0] lk_vpn;
    logic             lk_hit, ins_en, dset_en, chk_valid;
    logic [IDX_W-1:0] lk_idx, dset_idx;
    tlb_ent_t         lk_ent, ins_ent;
    acc_e             chk_kind;
    logic [RGT_W-1:0] chk_rights;
    flt_e             chk_fault;

    xlate_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ent(lk_ent),
        .ins_en(ins_en), .ins_ent(ins_ent),
        .dset_en(dset_en), .dset_idx(dset_idx)
    );

    xlate_rights u_rights (
        .kind(chk_kind), .pvalid(chk_valid), .rights(chk_rights), .fault(chk_fault)
    );

    xlate_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst), .flush(flush), .ptbr(ptbr),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .resp_dirty(resp_dirty),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ent(lk_ent),
        .ins_en(ins_en), .ins_ent(ins_ent),
        .dset_en(dset_en), .dset_idx(dset_idx),
        .chk_kind(chk_kind), .chk_valid(chk_valid),
        .chk_rights(chk_rights), .chk_fault(chk_fault)
    );
endmodule

// File: tb/tb_xlate_top.sv
`timescale 1ns/1ps
module tb_xlate_top;
    localparam int LAT  = 2;
    localparam int NENT = 8;

    logic        clk = 1'b0;
    logic        rst, flush, req_valid, mem_ack;
    logic [28:0] ptbr;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        req_ready, resp_valid, resp_dirty, mem_req;
    logic [28:0] resp_paddr, mem_addr;
    logic [1:0]  resp_fault;
    logic [16:0] mem_rdata;

    always #2 clk = ~clk;

    xlate_top #(.TLB_ENTRIES(NENT)) dut (
        .clk(clk), .rst(rst), .flush(flush), .ptbr(ptbr),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .resp_dirty(resp_dirty),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [16:0] ptab  [int];
    logic [16:0] cache [int];
    int          order [$];
    int          mcnt = 0;

    task automatic chk(bit c, string rq, string what, longint act, longint exp);
        n_tests++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [16:0] mk(bit v, bit d, int r, int ppn);
        return {v, d, 4'(r), 11'(ppn)};
    endfunction

    // memory responder: ack LAT negedges after mem_req is first seen
    always @(negedge clk) begin
        if (mem_req) begin
            int idx;
            mcnt++;
            idx = int'((mem_addr - ptbr) >> 2);
            if (mcnt == LAT) begin
                mem_ack   <= 1'b1;
                mem_rdata <= ptab.exists(idx) ? ptab[idx] : 17'h0;
            end else begin
                mem_ack <= 1'b0;
            end
        end else begin
            mcnt    = 0;
            mem_ack <= 1'b0;
        end
    end

    task automatic model_flush();
        order.delete();
        cache.delete();
    endtask

    task automatic do_req(int vpn, int off, int kind);
        bit          hit, rok, saw_mem, addr_ok;
        logic [16:0] e;
        int          fexp, lat, cyc;
        logic [28:0] pexp;
        bit          dexp;
        hit = 0;
        foreach (order[i]) if (order[i] == vpn) hit = 1;
        if (hit) e = cache[vpn];
        else begin
            e = ptab.exists(vpn) ? ptab[vpn] : 17'h0;
            if (e[16]) begin
                if (order.size() == NENT) begin
                    cache.delete(order[0]);
                    void'(order.pop_front());
                end
                order.push_back(vpn);
                cache[vpn] = e;
            end
        end
        rok  = (kind == 0) ? e[11] : (kind == 1) ? e[12] : e[13];
        fexp = !e[16] ? 1 : (!rok ? 2 : 0);
        if (fexp == 0) begin
            pexp = {e[10:0], 18'(off)};
            if (kind == 1) e[15] = 1'b1;
            dexp = e[15];
            cache[vpn] = e;
        end else begin
            pexp = '0;
            dexp = 1'b0;
        end
        lat = hit ? 1 : 1 + LAT;

        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = (32'(vpn) << 18) | 32'(off);
        req_kind  = 2'(kind);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; saw_mem = 0; addr_ok = 1;
        while (!resp_valid && cyc < 20) begin
            if (mem_req) begin
                saw_mem = 1;
                if (mem_addr != ptbr + 29'(vpn * 4)) addr_ok = 0;
            end
            @(negedge clk);
            cyc++;
        end
        if (hit) begin
            chk(cyc == lat, "R5", "hit latency", cyc, lat);
            chk(!saw_mem, "R5", "no memory read on hit", saw_mem, 0);
        end else begin
            chk(cyc == lat, "R6", "miss latency", cyc, lat);
            chk(saw_mem && addr_ok, "R2", "entry address", mem_addr, ptbr + 29'(vpn * 4));
        end
        chk(resp_fault == 2'(fexp), (fexp == 1) ? "R3" : "R4", "fault code", resp_fault, fexp);
        chk(resp_paddr == pexp, "R1", "physical address", resp_paddr, pexp);
        chk(resp_dirty == dexp, "R10", "dirty", resp_dirty, dexp);
        @(negedge clk);
        chk(!resp_valid, "R11", "single-cycle response", resp_valid, 0);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        #0;
        chk(!req_ready, "R7", "ready low during flush", req_ready, 0);
        @(negedge clk);
        flush = 1'b0;
        model_flush();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; flush = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
        mem_ack = 1'b0; mem_rdata = '0; ptbr = 29'h0100_0000;
        ptab[5]       = mk(1, 0, 4'b0011, 11'h123);
        ptab[6]       = mk(1, 0, 4'b0001, 11'h045);
        ptab[7]       = mk(1, 0, 4'b0101, 11'h7FF);
        ptab[8]       = mk(0, 0, 4'b0111, 11'h055);
        ptab[9]       = mk(1, 1, 4'b0000, 11'h010);
        ptab[14'h3FFF] = mk(1, 1, 4'b0111, 11'h001);
        for (int v = 20; v <= 28; v++) ptab[v] = mk(1, 0, 4'b0011, v + 11'h100);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0;
        chk(req_ready && !resp_valid && !mem_req, "R11", "reset state",
            {req_ready, resp_valid, mem_req}, 3'b100);

        // R1 R6 R5 R10: miss then hits, store sets dirty
        do_req(5, 18'h2ABCD, 0);
        do_req(5, 18'h00001, 0);
        do_req(5, 18'h10000, 1);
        do_req(5, 18'h3FFFF, 0);
        // R4: rights
        do_req(6, 18'h00100, 1);
        do_req(6, 18'h00104, 0);
        do_req(6, 18'h00108, 2);
        do_req(7, 18'h00200, 2);
        do_req(7, 18'h00204, 1);
        do_req(9, 18'h00300, 0);
        // R3: invalid entry not cached
        do_req(8, 18'h00400, 0);
        do_req(8, 18'h00404, 0);
        // top page, all-ones offset
        do_req(14'h3FFF, 18'h3FFFF, 2);
        // R7: flush forces a new table read, dirty from table again
        do_flush();
        do_req(5, 18'h00010, 0);
        // R9: round robin eviction
        do_flush();
        for (int v = 20; v <= 28; v++) do_req(v, 18'h00020, 0);
        do_req(21, 18'h00024, 0);
        do_req(20, 18'h00028, 0);
        // R8: flush during a table read
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = (32'(7) << 18) | 32'h40;
        req_kind  = 2'd0;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_flush();
        begin
            bit seen;
            seen = 0;
            for (int i = 0; i < 6; i++) begin
                if (resp_valid) seen = 1;
                @(negedge clk);
            end
            chk(!seen, "R8", "no response after aborted read", seen, 0);
        end
        do_req(7, 18'h00044, 0);
        do_req(7, 18'h00048, 2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule